// File: doc/BRIEF.md
# Stretched Chip Reset Generator with Mirrored Reset Pin

This block produces the active-low reset that the rest of the chip runs from. Three things can start a reset: the board-level reset pin going low, the supply-detect input showing that power is not yet good, and a one-cycle software reboot request. Any of them pulls the internal reset low. The pin and supply-detect inputs do this at once, through asynchronous clears, so a pin glitch shorter than a clock period is still caught. The internal reset then stays low until every source has been quiet for a fixed number of clock cycles. A source that returns during that count starts the count again from zero. Deassertion is always synchronous to the clock.

After supply detection, a separate power-up delay runs before the release count can begin. A mode strap chooses how the reset pin is used. With the strap high, the pin is a plain input. With the strap low, the block drives the internal reset level back onto the pin through a weak driver, so other devices on the board can share the reset. In that mode the pin is read back through a synchronizer. A readback low counts as an external reset only when the block itself was driving the pin high, once that drive has passed through the same number of stages as the readback. This keeps the block from holding itself in reset.

Top module: `rst_stretch`

## Requirements
- R1: While `por_n` is low, `rst_int_n` and `pin_out` are low.
- R2: After `por_n` rises, `rst_int_n` rises on the (POR_CYC+REL_CYC)-th rising clock edge, provided no other source is active.
- R3: With `strap_n` high, a low on `pin_in` of any width, including one that falls between two clock edges, drives `rst_int_n` low while the low lasts, without waiting for a clock edge.
- R4: With `strap_n` high, `rst_int_n` rises on the (SYNC_STAGES+REL_CYC)-th rising clock edge after `pin_in` returns high.
- R5: A new reset from any source that arrives while the release count is running stops that count. The full REL_CYC count restarts only once every source is quiet again.
- R6: `soft_req` high at a rising edge pulls `rst_int_n` low after that edge. If `soft_req` is low from the next edge on, `rst_int_n` rises on the REL_CYC-th edge at which `soft_req` is sampled low. This gives the same stretched release as a pin reset.
- R7: With `strap_n` high, `pin_oe` is 0 at all times.
- R8: With `strap_n` low, `pin_oe` is 1 and `pin_out` equals `rst_int_n`. The pin is therefore driven low during any reset, including a software reset, and driven high otherwise.
- R9: With `strap_n` low, a one-cycle external low on the pin does not reset the block at once. Suppose it starts after clock edge c. Then `rst_int_n` falls after edge c+SYNC_STAGES+1 and rises on edge c+SYNC_STAGES+1+REL_CYC.
- R10: With `strap_n` low, the block's own low on the pin never extends a reset. Every release time in R6 and R9 holds while the block mirrors its reset onto the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Supply-detect level, low while power is not good |
| pin_in | input | 1 | Level read from the reset pin, active low |
| soft_req | input | 1 | Software reboot request, active high, sampled on clock edges |
| strap_n | input | 1 | Mode strap: low mirrors the reset onto the pin, high makes the pin an input only |
| rst_int_n | output | 1 | Stretched chip reset, active low |
| pin_oe | output | 1 | Enable for the weak pin driver |
| pin_out | output | 1 | Level for the weak pin driver |

## Verification
Every release time has an exact due cycle. For a pin reset with the strap high, it is SYNC_STAGES+REL_CYC edges after the pin returns high. After supply detection it is POR_CYC+REL_CYC edges. For a software request it is REL_CYC edges after the request drops. For a mirrored-pin pulse it is SYNC_STAGES+1+REL_CYC edges after the pulse starts. The driver works out each due cycle from a free-running edge count when it applies the stimulus, and queues it. The monitor samples `rst_int_n` on falling clock edges and compares the edge count at each rising reset against the head of the queue. An unexpected release is an error, and so is an expected one that never arrives. Asynchronous assertion is checked mid-pulse, before the next clock edge. Mirroring is checked as levels on the modeled pin net.

// File: rtl/rststr_pkg.sv
package rststr_pkg;
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rststr_trap.sv
// Traps a low on the asynchronous source and releases it only through
// a chain of clocked stages, so release is always synchronous.
module rststr_trap #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic async_n,
  output logic quiet_o
);
  logic [SYNC_STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge async_n) begin
    if (!async_n) stage_q <= '0;
    else          stage_q <= {stage_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign quiet_o = stage_q[SYNC_STAGES-1];

  // R4: the last stage can only be set one edge after the stage before it
  assert_trap_order_R4: assert property (@(posedge clk) disable iff (!async_n)
    $rose(stage_q[SYNC_STAGES-1]) |-> $past(stage_q[SYNC_STAGES-2]));
endmodule

// File: rtl/rststr_por.sv
// Power-up delay: counts POR_CYC edges after supply detection.
module rststr_por #(
  parameter int POR_CYC = 8,
  parameter int CW      = 4
) (
  input  logic clk,
  input  logic por_n,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CW'(POR_CYC - 1)) done_q <= 1'b1;
      else                           cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;

  // R2: once the power-up delay ends it stays ended until supply loss
  assert_por_sticky_R2: assert property (@(posedge clk) disable iff (!por_n)
    done_q |=> done_q);
endmodule

// File: rtl/rststr_readback.sv
// Synchronizes the pin readback and compares it with the block's own
// drive level delayed by the same number of stages.
module rststr_readback #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic mirror,
  input  logic pin_in,
  input  logic drv_n,
  output logic ext_low_o
);
  logic [SYNC_STAGES-1:0] rb_q;
  logic [SYNC_STAGES-1:0] drv_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rb_q  <= '1;
      drv_q <= '0;
    end else begin
      rb_q  <= {rb_q[SYNC_STAGES-2:0], pin_in};
      drv_q <= {drv_q[SYNC_STAGES-2:0], drv_n};
    end
  end

  assign ext_low_o = mirror & ~rb_q[SYNC_STAGES-1] & drv_q[SYNC_STAGES-1];

  // R10: an external low is only recognized when the delayed drive was high
  assert_rb_gate_R10: assert property (@(posedge clk) disable iff (!por_n)
    ext_low_o |-> $past(drv_q[SYNC_STAGES-2]));
endmodule

// File: rtl/rststr_release.sv
// Release counter: holds reset until quiet for REL_CYC consecutive edges.
module rststr_release #(
  parameter int REL_CYC = 16,
  parameter int CW      = 5
) (
  input  logic clk,
  input  logic arst_n,
  input  logic quiet,
  output logic rst_n_o
);
  logic [CW-1:0] cnt_q;
  logic          rst_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else if (!quiet) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else if (!rst_q) begin
      if (cnt_q == CW'(REL_CYC - 1)) rst_q <= 1'b1;
      else                           cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_n_o = rst_q;

  // R5: any active source stops the count and holds reset
  assert_hold_on_source_R5: assert property (@(posedge clk) disable iff (!arst_n)
    !quiet |=> !rst_q);

  // R4: release only after the count reaches its end while quiet
  assert_full_count_R4: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_q) |-> ($past(cnt_q) == CW'(REL_CYC - 1)) && $past(quiet));
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int REL_CYC     = 16,
  parameter int POR_CYC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_in,
  input  logic soft_req,
  input  logic strap_n,
  output logic rst_int_n,
  output logic pin_oe,
  output logic pin_out
);
  import rststr_pkg::*;

  localparam int CW = $clog2(max2(REL_CYC, POR_CYC) + 1);

  logic async_n;
  logic pin_quiet;
  logic por_done;
  logic ext_low;
  logic all_quiet;
  logic mirror;

  assign mirror  = ~strap_n;
  // The pin clears asynchronously only when it is a pure input.
  assign async_n = por_n & (pin_in | mirror);

  rststr_trap #(.SYNC_STAGES(SYNC_STAGES)) u_trap (
    .clk     (clk),
    .async_n (async_n),
    .quiet_o (pin_quiet)
  );

  rststr_por #(.POR_CYC(POR_CYC), .CW(CW)) u_por (
    .clk    (clk),
    .por_n  (por_n),
    .done_o (por_done)
  );

  rststr_readback #(.SYNC_STAGES(SYNC_STAGES)) u_rb (
    .clk       (clk),
    .por_n     (por_n),
    .mirror    (mirror),
    .pin_in    (pin_in),
    .drv_n     (rst_int_n),
    .ext_low_o (ext_low)
  );

  assign all_quiet = pin_quiet & por_done & ~soft_req & ~ext_low;

  rststr_release #(.REL_CYC(REL_CYC), .CW(CW)) u_rel (
    .clk     (clk),
    .arst_n  (async_n),
    .quiet   (all_quiet),
    .rst_n_o (rst_int_n)
  );

  assign pin_oe  = mirror;
  assign pin_out = rst_int_n;

  // R6: a software request resets the chip after the edge that samples it
  assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!async_n)
    soft_req |=> !rst_int_n);

  // R2: reset is held for the whole power-up delay
  assert_por_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
    !por_done |=> !rst_int_n);
endmodule

// File: tb/test_rst_stretch.sv
`timescale 1ns/1ps
module test_rst_stretch;
  localparam int REL  = 12;
  localparam int POR  = 6;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic por_n = 1'b1;
  logic ext_low = 1'b0;
  logic soft_req = 1'b0;
  logic strap_n = 1'b1;
  logic rst_int_n, pin_oe, pin_out;
  logic pin_net;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  int   exp_q[$];
  logic prev_rst = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Board pin: external strong low, else weak drive, else external pull-up.
  assign pin_net = ext_low ? 1'b0 : (pin_oe ? pin_out : 1'b1);

  rst_stretch #(.REL_CYC(REL), .POR_CYC(POR), .SYNC_STAGES(SYNC)) i_rst_stretch (
    .clk(clk), .por_n(por_n), .pin_in(pin_net), .soft_req(soft_req),
    .strap_n(strap_n), .rst_int_n(rst_int_n), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: each rising reset is compared against the queued due cycle.
  always @(negedge clk) begin
    if (rst_int_n === 1'b1 && prev_rst !== 1'b1) begin
      if (exp_q.size() == 0) check("release unexpected", cyc, -1);
      else check("release cycle", cyc, exp_q.pop_front());
    end
    prev_rst <= rst_int_n;
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    wait_neg(REL + POR + 6);
    check(tag, exp_q.size(), 0);
    check(tag, int'(rst_int_n), 1);
  endtask

  initial begin
    #(200000 * 4);
    check("watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c;
    #1 por_n = 1'b0;
    wait_neg(3);
    check("R1 rst low in por", int'(rst_int_n), 0);
    check("R1 pin_out low in por", int'(pin_out), 0);
    check("R7 oe off", int'(pin_oe), 0);
    c = cyc; por_n = 1'b1; exp_q.push_back(c + POR + REL);
    wait_neg(POR + REL - 1);
    check("R2 still low before due", int'(rst_int_n), 0);
    drain("R2 por release");

    // R3: sub-cycle pulse caught without a clock edge
    @(negedge clk); c = cyc;
    #0.5 ext_low = 1'b1;
    #0.5 check("R3 async assert", int'(rst_int_n), 0);
    #0.5 ext_low = 1'b0;
    exp_q.push_back(c + SYNC + REL);
    drain("R3 pulse release");

    // R4: long pin low, release timed from return high
    @(negedge clk); ext_low = 1'b1;
    wait_neg(5);
    check("R4 held while pin low", int'(rst_int_n), 0);
    check("R7 oe off in reset", int'(pin_oe), 0);
    c = cyc; ext_low = 1'b0; exp_q.push_back(c + SYNC + REL);
    drain("R4 pin release");

    // R5: new pulse mid-count restarts the whole delay
    @(negedge clk); ext_low = 1'b1;
    @(negedge clk); ext_low = 1'b0;
    wait_neg(5);
    ext_low = 1'b1;
    @(negedge clk); c = cyc; ext_low = 1'b0;
    exp_q.push_back(c + SYNC + REL);
    wait_neg(REL);
    check("R5 still low after restart", int'(rst_int_n), 0);
    drain("R5 restart release");

    // R6: soft reset, one-cycle and three-cycle requests
    @(negedge clk); soft_req = 1'b1;
    @(negedge clk); c = cyc; soft_req = 1'b0;
    check("R6 soft asserts", int'(rst_int_n), 0);
    exp_q.push_back(c + REL);
    drain("R6 soft release");
    @(negedge clk); soft_req = 1'b1;
    wait_neg(3); c = cyc; soft_req = 1'b0;
    exp_q.push_back(c + REL);
    drain("R6 long soft release");

    // R8: strap low mirrors reset onto the pin
    @(negedge clk); strap_n = 1'b0;
    #0.5;
    check("R8 oe on", int'(pin_oe), 1);
    check("R8 pin high idle", int'(pin_net), 1);
    @(negedge clk); soft_req = 1'b1;
    @(negedge clk); c = cyc; soft_req = 1'b0;
    check("R8 pin low in soft reset", int'(pin_net), 0);
    exp_q.push_back(c + REL);
    wait_neg(2);
    check("R8 pin_out follows", int'(pin_out), int'(rst_int_n));
    drain("R10 soft release while mirrored");
    check("R8 pin high after", int'(pin_net), 1);

    // R9: external one-cycle low on mirrored pin
    @(negedge clk); c = cyc;
    #0.5 ext_low = 1'b1;
    #0.5 check("R9 no async in mirror", int'(rst_int_n), 1);
    @(negedge clk); ext_low = 1'b0;
    exp_q.push_back(c + SYNC + 1 + REL);
    wait_neg(SYNC - 1);
    check("R9 high before detect", int'(rst_int_n), 1);
    @(negedge clk);
    check("R9 low after detect", int'(rst_int_n), 0);
    check("R9 pin driven low", int'(pin_net), 0);
    drain("R10 release after mirrored pulse");

    // R1: supply loss in mirror mode
    @(negedge clk); #0.5 por_n = 1'b0;
    #0.5 check("R1 async por", int'(rst_int_n), 0);
    check("R1 pin low", int'(pin_net), 0);
    @(negedge clk); c = cyc; por_n = 1'b1;
    exp_q.push_back(c + POR + REL);
    drain("R2 por release mirrored");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule